// File: doc/BRIEF.md
# Slave Configuration Table and Address Decoder

This block is the register-access front end of a serial-attached slave. A single 32-bit request port (valid, write, byte address, byte count, write data) addresses a 2 MiB window. The block sorts each accepted request into one of three claimed regions or into unclaimed space. The lowest 1 KiB is a read-only configuration table. It gives the chip identifier first and then one self-describing word for each attached engine. The 1 KiB at 0x800 is a slave control window and the 1 KiB at 0xC00 is a local-bus window for engines. Accesses to these two windows leave the block on pass-through request ports and wait there for a response. Unclaimed space reads as zero and ignores writes.

Each engine descriptor packs a continuation flag in bit 31 and a slot count of one in bits [23:16]. A version field sits in the upper half of the low 16 bits, an engine type in bits [7:4] and a 4-bit check code in bits [3:0]. A break code written to either of the first two table words is not stored. Instead it makes the block pulse a synchronous cold reset toward the local bus. The request port takes one access at a time. Table and unclaimed accesses answer in the cycle after acceptance. Window accesses answer in the cycle after the downstream response arrives.

Top module: `cfg_slave_front`

## Requirements
- R1: After reset, rsp_valid, lb_cold_rst, ctl_req_valid and lb_req_valid are low and req_ready is high.
- R2: A 4-byte read (req_size = 3'd4) of address 0x000 returns 0xC0022D15 with rsp_err low.
- R3: 4-byte reads of 0x004, 0x008 and 0x00C return the descriptors 0x8001102C (type 2, version 0x1000, check 0xC), 0x8001503A (type 3, version 0x5000, check 0xA) and 0x80011067 (type 6, version 0x1000, check 0x7).
- R4: 4-byte reads of table addresses 0x010 to 0x3FF return zero with rsp_err low.
- R5: A 4-byte write of 0xC0DE0000 to 0x000 or 0x004 drives lb_cold_rst high for exactly one cycle, the cycle after acceptance, which is the same cycle as its rsp_valid.
- R6: Table writes with any other data, or to any other table address, raise no cold reset and leave every table read value unchanged.
- R7: A table access whose req_size is not 4, or whose address has bits [1:0] nonzero, responds with rsp_err high and rsp_rdata zero, and raises no cold reset even with break data.
- R8: Accesses to 0x400–0x7FF and to 0x1000 and above answer with zero data and rsp_err low, and they raise no downstream request.
- R9: An access to 0x800–0xBFF raises ctl_req_valid for one cycle, the cycle after acceptance, with ctl_req_addr = address − 0x800 and with write, data and size forwarded.
- R10: An access to 0xC00–0xFFF does the same on the lb_req_* port with lb_req_addr = address − 0xC00.
- R11: While a window access is pending, req_ready is low and new requests are not taken. rsp_valid rises the cycle after the selected window's rsp_valid and carries its data. A response from a window with nothing pending is ignored.
- R12: Table and unclaimed accesses give a one-cycle rsp_valid in the cycle after acceptance, and req_ready stays high, so a new request can be accepted in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 21 | Byte address in the 2 MiB window |
| req_size | input | 3 | Access size in bytes |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Request accepted when high with req_valid |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | 32 | Response read data |
| rsp_err | output | 1 | Illegal table access |
| lb_cold_rst | output | 1 | One-cycle local-bus cold reset pulse |
| ctl_req_valid | output | 1 | Control window request pulse |
| ctl_req_write | output | 1 | Control window write flag |
| ctl_req_addr | output | 21 | Control window local offset |
| ctl_req_size | output | 3 | Control window access size |
| ctl_req_wdata | output | 32 | Control window write data |
| ctl_rsp_valid | input | 1 | Control window response strobe |
| ctl_rsp_rdata | input | 32 | Control window response data |
| lb_req_valid | output | 1 | Local-bus request pulse |
| lb_req_write | output | 1 | Local-bus write flag |
| lb_req_addr | output | 21 | Local-bus local offset |
| lb_req_size | output | 3 | Local-bus access size |
| lb_req_wdata | output | 32 | Local-bus write data |
| lb_rsp_valid | input | 1 | Local-bus response strobe |
| lb_rsp_rdata | input | 32 | Local-bus response data |

## Verification
The assertions assume that a downstream window sends a response only after it has seen its request pulse. They also assume at most one response per request. The responder in the bench follows this rule: it strobes a window response only after a request, after a chosen latency of zero or more cycles. The one exception is a deliberate stray strobe sent while idle, which the design must ignore. The bench also holds req_valid high through a pending window access. This checks that the request is neither taken early nor lost once the block becomes ready again.

// File: rtl/cfs_pkg.sv
package cfs_pkg;
   typedef enum logic [1:0] {RG_CFG, RG_CTL, RG_LB, RG_NONE} region_t;

   localparam logic [31:0] CHIP_ID_WORD = 32'hC002_2D15;
   localparam logic [31:0] BREAK_CODE   = 32'hC0DE_0000;
   localparam int          NUM_ENG      = 3;

   function automatic logic [31:0] pack_desc(input logic more, input logic [15:0] ver,
                                             input logic [3:0] kind, input logic [3:0] chk);
      return {more, 31'd0} | 32'h0001_0000 | {16'd0, ver} | {24'd0, kind, 4'd0} | {28'd0, chk};
   endfunction

   function automatic logic [31:0] engine_desc(input int idx);
      case (idx)
         0:       return pack_desc(1'b1, 16'h1000, 4'd2, 4'hC);
         1:       return pack_desc(1'b1, 16'h5000, 4'd3, 4'hA);
         2:       return pack_desc(1'b1, 16'h1000, 4'd6, 4'h7);
         default: return 32'd0;
      endcase
   endfunction
endpackage

// File: rtl/cfs_decode.sv
module cfs_decode
   import cfs_pkg::*;
#(
   parameter int AW       = 21,
   parameter int CFG_SPAN = 1024,
   parameter int CTL_BASE = 2048,
   parameter int CTL_SPAN = 1024,
   parameter int LB_BASE  = 3072,
   parameter int LB_SPAN  = 1024
) (
   input  logic [AW-1:0] addr,
   output region_t       region,
   output logic [AW-1:0] local_off
);
   localparam logic [AW:0] CFG_END = (AW+1)'(CFG_SPAN);
   localparam logic [AW:0] CTL_LO  = (AW+1)'(CTL_BASE);
   localparam logic [AW:0] CTL_HI  = (AW+1)'(CTL_BASE + CTL_SPAN);
   localparam logic [AW:0] LB_LO   = (AW+1)'(LB_BASE);
   localparam logic [AW:0] LB_HI   = (AW+1)'(LB_BASE + LB_SPAN);

   generate
      if (CTL_BASE < CFG_SPAN || LB_BASE < CTL_BASE + CTL_SPAN)
         $error("cfs_decode: regions overlap");
      if (LB_BASE + LB_SPAN > (1 << AW))
         $error("cfs_decode: window exceeds address space");
   endgenerate

   logic [AW:0] a_ext;
   assign a_ext = {1'b0, addr};

   always_comb begin
      region    = RG_NONE;
      local_off = addr;
      if (a_ext < CFG_END) begin
         region = RG_CFG;
      end else if (a_ext >= CTL_LO && a_ext < CTL_HI) begin
         region    = RG_CTL;
         local_off = AW'(a_ext - CTL_LO);
      end else if (a_ext >= LB_LO && a_ext < LB_HI) begin
         region    = RG_LB;
         local_off = AW'(a_ext - LB_LO);
      end
   end
endmodule

// File: rtl/cfs_table.sv
module cfs_table
   import cfs_pkg::*;
#(
   parameter int AW   = 21,
   parameter int DW   = 32,
   parameter int NENG = NUM_ENG
) (
   input  logic [AW-1:0] off,
   input  logic [2:0]    size,
   input  logic          write,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata,
   output logic          err,
   output logic          brk
);
   localparam int IW = AW - 2;

   generate
      if (DW != 32) $error("cfs_table: table words are 32 bits");
      if (NENG < 1 || NENG > NUM_ENG) $error("cfs_table: engine count out of range");
   endgenerate

   logic [DW-1:0] rom [NENG+1];
   logic [IW-1:0] idx;
   assign idx = off[AW-1:2];

   generate
      for (genvar g = 0; g <= NENG; g++) begin : g_rom
         if (g == 0) begin : g_id
            assign rom[g] = CHIP_ID_WORD;
         end else begin : g_eng
            assign rom[g] = engine_desc(g - 1);
         end
      end
   endgenerate

   always_comb begin
      err   = (size != 3'd4) || (off[1:0] != 2'b00);
      rdata = '0;
      brk   = 1'b0;
      if (!err) begin
         if (write) begin
            brk = (wdata == BREAK_CODE) && (idx == IW'(0) || idx == IW'(1));
         end else begin
            for (int k = 0; k <= NENG; k++)
               if (idx == IW'(k)) rdata = rom[k];
         end
      end
   end
endmodule

// File: rtl/cfs_dnport.sv
module cfs_dnport #(
   parameter int AW = 21,
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          launch,
   input  logic [AW-1:0] addr,
   input  logic          write,
   input  logic [2:0]    size,
   input  logic [DW-1:0] wdata,
   output logic          dn_valid,
   output logic [AW-1:0] dn_addr,
   output logic          dn_write,
   output logic [2:0]    dn_size,
   output logic [DW-1:0] dn_wdata
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dn_valid <= 1'b0;
         dn_addr  <= '0;
         dn_write <= 1'b0;
         dn_size  <= '0;
         dn_wdata <= '0;
      end else begin
         dn_valid <= launch;
         if (launch) begin
            dn_addr  <= addr;
            dn_write <= write;
            dn_size  <= size;
            dn_wdata <= wdata;
         end
      end
   end

   AST_DN_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      dn_valid |=> !dn_valid); // R9
endmodule

// File: rtl/cfg_slave_front.sv
module cfg_slave_front
   import cfs_pkg::*;
#(
   parameter int AW       = 21,
   parameter int DW       = 32,
   parameter int CFG_SPAN = 1024,
   parameter int CTL_BASE = 2048,
   parameter int CTL_SPAN = 1024,
   parameter int LB_BASE  = 3072,
   parameter int LB_SPAN  = 1024
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic          req_write,
   input  logic [AW-1:0] req_addr,
   input  logic [2:0]    req_size,
   input  logic [DW-1:0] req_wdata,
   output logic          req_ready,
   output logic          rsp_valid,
   output logic [DW-1:0] rsp_rdata,
   output logic          rsp_err,
   output logic          lb_cold_rst,
   output logic          ctl_req_valid,
   output logic          ctl_req_write,
   output logic [AW-1:0] ctl_req_addr,
   output logic [2:0]    ctl_req_size,
   output logic [DW-1:0] ctl_req_wdata,
   input  logic          ctl_rsp_valid,
   input  logic [DW-1:0] ctl_rsp_rdata,
   output logic          lb_req_valid,
   output logic          lb_req_write,
   output logic [AW-1:0] lb_req_addr,
   output logic [2:0]    lb_req_size,
   output logic [DW-1:0] lb_req_wdata,
   input  logic          lb_rsp_valid,
   input  logic [DW-1:0] lb_rsp_rdata
);
   localparam int NWIN = 2;

   generate
      if (AW < 12) $error("cfg_slave_front: address too narrow for the windows");
   endgenerate

   typedef enum logic {ST_IDLE, ST_WAIT} state_t;
   state_t  st;
   logic    win_q;
   region_t rg;
   logic [AW-1:0] loff;
   logic [DW-1:0] t_rdata;
   logic t_err, t_brk, accept;
   logic dn_rsp_v;
   logic [DW-1:0] dn_rsp_d;

   cfs_decode #(.AW(AW), .CFG_SPAN(CFG_SPAN), .CTL_BASE(CTL_BASE), .CTL_SPAN(CTL_SPAN),
                .LB_BASE(LB_BASE), .LB_SPAN(LB_SPAN)) u_dec (
      .addr(req_addr), .region(rg), .local_off(loff));

   cfs_table #(.AW(AW), .DW(DW), .NENG(NUM_ENG)) u_tab (
      .off(loff), .size(req_size), .write(req_write), .wdata(req_wdata),
      .rdata(t_rdata), .err(t_err), .brk(t_brk));

   assign req_ready = (st == ST_IDLE);
   assign accept    = req_valid && req_ready;

   logic [NWIN-1:0] launch, dn_v, dn_w;
   logic [AW-1:0]   dn_a [NWIN];
   logic [2:0]      dn_s [NWIN];
   logic [DW-1:0]   dn_d [NWIN];

   assign launch[0] = accept && (rg == RG_CTL);
   assign launch[1] = accept && (rg == RG_LB);

   generate
      for (genvar w = 0; w < NWIN; w++) begin : g_win
         cfs_dnport #(.AW(AW), .DW(DW)) u_port (
            .clk(clk), .rst_n(rst_n), .launch(launch[w]), .addr(loff),
            .write(req_write), .size(req_size), .wdata(req_wdata),
            .dn_valid(dn_v[w]), .dn_addr(dn_a[w]), .dn_write(dn_w[w]),
            .dn_size(dn_s[w]), .dn_wdata(dn_d[w]));
      end
   endgenerate

   assign ctl_req_valid = dn_v[0];
   assign ctl_req_write = dn_w[0];
   assign ctl_req_addr  = dn_a[0];
   assign ctl_req_size  = dn_s[0];
   assign ctl_req_wdata = dn_d[0];
   assign lb_req_valid  = dn_v[1];
   assign lb_req_write  = dn_w[1];
   assign lb_req_addr   = dn_a[1];
   assign lb_req_size   = dn_s[1];
   assign lb_req_wdata  = dn_d[1];

   assign dn_rsp_v = win_q ? lb_rsp_valid : ctl_rsp_valid;
   assign dn_rsp_d = win_q ? lb_rsp_rdata : ctl_rsp_rdata;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st          <= ST_IDLE;
         win_q       <= 1'b0;
         rsp_valid   <= 1'b0;
         rsp_rdata   <= '0;
         rsp_err     <= 1'b0;
         lb_cold_rst <= 1'b0;
      end else begin
         rsp_valid   <= 1'b0;
         rsp_err     <= 1'b0;
         lb_cold_rst <= 1'b0;
         case (st)
            ST_IDLE: if (accept) begin
               case (rg)
                  RG_CFG: begin
                     rsp_valid   <= 1'b1;
                     rsp_rdata   <= t_rdata;
                     rsp_err     <= t_err;
                     lb_cold_rst <= t_brk;
                  end
                  RG_CTL: begin
                     st    <= ST_WAIT;
                     win_q <= 1'b0;
                  end
                  RG_LB: begin
                     st    <= ST_WAIT;
                     win_q <= 1'b1;
                  end
                  default: begin
                     rsp_valid <= 1'b1;
                     rsp_rdata <= '0;
                  end
               endcase
            end
            ST_WAIT: if (dn_rsp_v) begin
               st        <= ST_IDLE;
               rsp_valid <= 1'b1;
               rsp_rdata <= dn_rsp_d;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   AST_COLD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      lb_cold_rst |=> !lb_cold_rst); // R5
   AST_COLD_WITH_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      lb_cold_rst |-> (rsp_valid && !rsp_err)); // R5
   AST_ERR_NO_COLD: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> (!lb_cold_rst && rsp_rdata == '0)); // R7
   AST_ONE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ctl_req_valid, lb_req_valid})); // R10
   AST_WAIT_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_req_valid || lb_req_valid) |-> !req_ready); // R11
   AST_RSP_AFTER_DN: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WAIT && dn_rsp_v) |=> (rsp_valid && req_ready && !rsp_err)); // R11
   AST_LOCAL_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && (rg == RG_CFG || rg == RG_NONE)) |=> (rsp_valid && req_ready)); // R12
endmodule

// File: tb/sim_cfg_slave_front.sv
module sim_cfg_slave_front;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 0, req_write = 0;
   logic [20:0] req_addr = '0;
   logic [2:0]  req_size = '0;
   logic [31:0] req_wdata = '0;
   logic ctl_rsp_valid = 0, lb_rsp_valid = 0;
   logic [31:0] ctl_rsp_rdata = '0, lb_rsp_rdata = '0;
   logic req_ready, rsp_valid, rsp_err, lb_cold_rst;
   logic [31:0] rsp_rdata;
   logic ctl_req_valid, ctl_req_write, lb_req_valid, lb_req_write;
   logic [20:0] ctl_req_addr, lb_req_addr;
   logic [2:0]  ctl_req_size, lb_req_size;
   logic [31:0] ctl_req_wdata, lb_req_wdata;

   always #(CLK_PERIOD/2) clk = ~clk;

   cfg_slave_front u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
      .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .rsp_err(rsp_err), .lb_cold_rst(lb_cold_rst),
      .ctl_req_valid(ctl_req_valid), .ctl_req_write(ctl_req_write),
      .ctl_req_addr(ctl_req_addr), .ctl_req_size(ctl_req_size),
      .ctl_req_wdata(ctl_req_wdata), .ctl_rsp_valid(ctl_rsp_valid),
      .ctl_rsp_rdata(ctl_rsp_rdata), .lb_req_valid(lb_req_valid),
      .lb_req_write(lb_req_write), .lb_req_addr(lb_req_addr),
      .lb_req_size(lb_req_size), .lb_req_wdata(lb_req_wdata),
      .lb_rsp_valid(lb_rsp_valid), .lb_rsp_rdata(lb_rsp_rdata));

   int n_run = 0, n_fail = 0;
   bit done = 0;
   string cur_req = "R1";

   // reference model state
   bit m_busy = 0, m_win = 0;
   bit e_rv = 0, e_err = 0, e_cold = 0, e_cv = 0, e_lv = 0;
   logic [31:0] e_rd = '0, e_dd = '0;
   logic [20:0] e_da = '0;
   logic e_dw = 0;
   logic [2:0] e_ds = '0;

   function automatic logic [31:0] table_val(input int a);
      if (a == 0)  return 32'hC0022D15;
      if (a == 4)  return 32'h8001102C;
      if (a == 8)  return 32'h8001503A;
      if (a == 12) return 32'h80011067;
      return 32'h0;
   endfunction

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
      end
   endtask

   task automatic compare();
      chk("req_ready", 32'(req_ready), 32'(!m_busy));
      chk("rsp_valid", 32'(rsp_valid), 32'(e_rv));
      if (e_rv) begin
         chk("rsp_rdata", rsp_rdata, e_rd);
         chk("rsp_err", 32'(rsp_err), 32'(e_err));
      end
      chk("lb_cold_rst", 32'(lb_cold_rst), 32'(e_cold));
      chk("ctl_req_valid", 32'(ctl_req_valid), 32'(e_cv));
      chk("lb_req_valid", 32'(lb_req_valid), 32'(e_lv));
      if (e_cv) begin
         chk("ctl_addr", 32'(ctl_req_addr), 32'(e_da));
         chk("ctl_wdata", ctl_req_wdata, e_dd);
         chk("ctl_write", 32'(ctl_req_write), 32'(e_dw));
         chk("ctl_size", 32'(ctl_req_size), 32'(e_ds));
      end
      if (e_lv) begin
         chk("lb_addr", 32'(lb_req_addr), 32'(e_da));
         chk("lb_wdata", lb_req_wdata, e_dd);
         chk("lb_write", 32'(lb_req_write), 32'(e_dw));
         chk("lb_size", 32'(lb_req_size), 32'(e_ds));
      end
   endtask

   // one clock: predict from the inputs now applied, then compare after the edge
   task automatic tick();
      bit nv = 0, ne = 0, nc = 0, ncv = 0, nlv = 0;
      logic [31:0] nd = '0;
      if (!m_busy && req_valid) begin
         int a = int'(req_addr);
         if (a < 'h400) begin
            nv = 1;
            if (req_size != 3'd4 || (a % 4) != 0) ne = 1;
            else if (req_write) nc = (a == 0 || a == 4) && (req_wdata == 32'hC0DE0000);
            else nd = table_val(a);
         end else if ((a >= 'h800 && a < 'hC00) || (a >= 'hC00 && a < 'h1000)) begin
            m_busy = 1;
            m_win  = (a >= 'hC00);
            if (m_win) nlv = 1; else ncv = 1;
            e_da = 21'(a - (m_win ? 'hC00 : 'h800));
            e_dd = req_wdata; e_dw = req_write; e_ds = req_size;
         end else begin
            nv = 1;
         end
      end else if (m_busy) begin
         if (m_win ? lb_rsp_valid : ctl_rsp_valid) begin
            nv = 1;
            nd = m_win ? lb_rsp_rdata : ctl_rsp_rdata;
            m_busy = 0;
         end
      end
      @(posedge clk);
      @(negedge clk);
      e_rv = nv; e_rd = nd; e_err = ne; e_cold = nc; e_cv = ncv; e_lv = nlv;
      compare();
   endtask

   task automatic acc(input bit w, input int a, input logic [31:0] d, input logic [2:0] sz);
      req_valid = 1; req_write = w; req_addr = 21'(a); req_wdata = d; req_size = sz;
      tick();
      req_valid = 0;
   endtask

   task automatic win_rsp(input bit lb, input int lat, input logic [31:0] d);
      repeat (lat) tick();
      if (lb) begin lb_rsp_valid = 1; lb_rsp_rdata = d; end
      else    begin ctl_rsp_valid = 1; ctl_rsp_rdata = d; end
      tick();
      lb_rsp_valid = 0; ctl_rsp_valid = 0;
      tick();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      cur_req = "R1"; compare();
      tick();

      cur_req = "R2"; acc(0, 'h000, 0, 3'd4); tick();
      cur_req = "R3"; acc(0, 'h004, 0, 3'd4); acc(0, 'h008, 0, 3'd4); acc(0, 'h00C, 0, 3'd4); tick();
      cur_req = "R4"; acc(0, 'h010, 0, 3'd4); acc(0, 'h3FC, 0, 3'd4); acc(0, 'h200, 0, 3'd4); tick();
      cur_req = "R5"; acc(1, 'h000, 32'hC0DE0000, 3'd4); tick(); tick();
      acc(1, 'h004, 32'hC0DE0000, 3'd4); acc(0, 'h004, 0, 3'd4); tick();
      cur_req = "R6"; acc(1, 'h000, 32'hC0DE0001, 3'd4); acc(1, 'h008, 32'hC0DE0000, 3'd4);
      acc(1, 'h00C, 32'h12345678, 3'd4); acc(1, 'h004, 32'hFFFFFFFF, 3'd4);
      acc(0, 'h008, 0, 3'd4); acc(0, 'h00C, 0, 3'd4); acc(0, 'h000, 0, 3'd4); tick();
      cur_req = "R7"; acc(1, 'h000, 32'hC0DE0000, 3'd2); acc(0, 'h004, 0, 3'd1);
      acc(1, 'h005, 32'hC0DE0000, 3'd4); acc(0, 'h002, 0, 3'd4); tick();
      cur_req = "R8"; acc(0, 'h400, 0, 3'd4); acc(1, 'h7FC, 32'hC0DE0000, 3'd4);
      acc(0, 'h1000, 0, 3'd4); acc(0, 21'h1FFFFC, 0, 3'd2); tick();
      cur_req = "R9"; acc(0, 'h800, 0, 3'd4); tick(); win_rsp(0, 2, 32'hA5A5_0001);
      acc(1, 'hBFC, 32'hDEAD_BEEF, 3'd2); win_rsp(0, 0, 32'h0000_0042);
      cur_req = "R10"; acc(0, 'hC00, 0, 3'd4); tick(); win_rsp(1, 3, 32'h1122_3344);
      acc(1, 'hFF8, 32'h0BAD_F00D, 3'd1); win_rsp(1, 1, 32'h5555_AAAA);
      cur_req = "R11";
      ctl_rsp_valid = 1; ctl_rsp_rdata = 32'hFFFF_0000; tick(); ctl_rsp_valid = 0; tick();
      req_valid = 1; req_write = 0; req_addr = 21'h820; req_size = 3'd4; tick();
      req_addr = 21'h00C; tick(); tick();
      lb_rsp_valid = 1; lb_rsp_rdata = 32'h7777_7777; tick(); lb_rsp_valid = 0;
      ctl_rsp_valid = 1; ctl_rsp_rdata = 32'hCAFE_0011; tick(); ctl_rsp_valid = 0;
      tick(); req_valid = 0; tick(); tick();
      cur_req = "R12";
      req_valid = 1; req_write = 0; req_size = 3'd4;
      for (int i = 0; i < 8; i++) begin req_addr = 21'(i * 4); tick(); end
      req_valid = 0; tick(); tick();

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog %s actual=hung expected=finished", cur_req);
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule